// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Scheduler

This block keeps three transmit mailboxes for a CAN controller and decides which waiting frame the protocol engine sends next. Software fills a mailbox through a register port with an identifier word, a 4-bit length code and two data words. Writing the identifier word with its request bit set queues the frame. The scheduler always offers the pending frame with the best bus priority. The engine takes the offer with a start pulse and closes the attempt with a success pulse or a lost/error pulse.

A status word shows per-mailbox empty, pending, abort and success flags. It also holds a two-bit code that names the lowest free mailbox, or the pending mailbox that is worst on priority when none is free. Software uses that code to pick a slot, or a victim to abort. An abort request takes effect at once on a waiting mailbox. On a mailbox that the engine is already sending, the abort waits for the engine's verdict, so a frame that reached the bus still reports success.

Top module: `can_tx_mailbox_sched`

## Requirements
- R1: After reset all three mailboxes are empty. The status word reads 0x0000_0007, with empty flags at bits 2:0, pending at 5:3, abort at 8:6, success at 11:9 and the code at 13:12. `offer_valid` is low.
- R2: Address 4*m+f selects mailbox m, with field f = 0 for the identifier, 1 for the length, 2 for the low data word and 3 for the high data word. A write to any field of an empty mailbox stores it. An identifier write with bit 0 set makes the mailbox pending, clears its empty flag and clears its success flag. Any write to a non-empty mailbox is ignored. Bit 0 of the identifier readback shows the pending state.
- R3: Bit 2 of the identifier word is the extended flag and bit 1 is the remote flag. A standard ID occupies bits 31:21; an extended ID occupies bits 31:3. Priority is decided by these rules, in order:
  - A lower base ID (bits 31:21) wins.
  - On an equal base ID, a standard frame beats an extended frame.
  - Between two extended frames, lower bits 20:3 win.
  - On an equal ID, a data frame beats a remote frame.
  - Bits 20:3 of a standard word take no part in priority.
- R4: Among pending mailboxes of identical priority, the lowest index is offered.
- R5: The status code holds the lowest index of an empty mailbox. When no mailbox is empty, it holds the mailbox with the lowest priority; among equals, the highest index.
- R6: While offering, `offer_idx`, `offer_ident`, `offer_len`, `offer_dlo` and `offer_dhi` present the selected mailbox's stored contents. The length is 4 bits wide.
- R7: A start pulse while `offer_valid` is high locks the offered mailbox until a done or lost pulse. While locked, `offer_valid` is low, and an abort on that mailbox stays pending.
- R8: A done pulse empties the locked mailbox, sets its success flag and clears its abort flag.
- R9: Writing status address 12 with bit 6+m set requests an abort of mailbox m. The abort flag is visible one cycle after the write. A mailbox that is not locked then empties with its success flag clear on the next edge, and an aborting mailbox is not offered. An abort of an empty mailbox is ignored.
- R10: A lost pulse with `auto_retry` high and no abort pending leaves the mailbox pending, and it is arbitrated again. With `auto_retry` low, or an abort pending, a lost pulse empties the mailbox with its success flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_retry | input | 1 | Keep a frame pending after a lost attempt |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| offer_valid | output | 1 | A frame is offered to the engine |
| offer_idx | output | 2 | Offered (or locked) mailbox index |
| offer_ident | output | 32 | Offered identifier word |
| offer_len | output | 4 | Offered length code |
| offer_dlo | output | 32 | Offered data bytes 0-3 |
| offer_dhi | output | 32 | Offered data bytes 4-7 |
| eng_start | input | 1 | Engine takes the offered frame |
| eng_done_ok | input | 1 | Engine finished the frame successfully |
| eng_lost | input | 1 | Engine lost arbitration or hit an error |

## Verification
Mailbox contents, flags and the status code change one clock edge after a write or engine pulse. The offer is decoded combinationally from that state, so it is due in the same cycle as the status. An abort shows its flag after the first edge and resolves on the second. The bench drives every input at a falling edge, waits one rising edge, and samples at the next falling edge. For aborts it checks the intermediate cycle and then waits one more cycle before comparing against its model.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

    localparam int MB_COUNT   = 3;
    localparam int MB_IDX_W   = $clog2(MB_COUNT);
    localparam int WORD_W     = 32;
    localparam int LEN_W      = 4;
    localparam int FIELD_W    = 2;
    localparam int ADDR_W     = MB_IDX_W + FIELD_W;
    localparam int STD_ID_W   = 11;
    localparam int EXT_LSB    = 3;
    localparam int EXT_LO_W   = WORD_W - STD_ID_W - EXT_LSB;
    localparam int IDE_BIT    = 2;
    localparam int RTR_BIT    = 1;
    localparam int REQ_BIT    = 0;
    localparam int KEY_W      = STD_ID_W + 1 + EXT_LO_W + 1;

    localparam int ST_EMPTY_LSB = 0;
    localparam int ST_PEND_LSB  = ST_EMPTY_LSB + MB_COUNT;
    localparam int ST_ABORT_LSB = ST_PEND_LSB + MB_COUNT;
    localparam int ST_OK_LSB    = ST_ABORT_LSB + MB_COUNT;
    localparam int ST_CODE_LSB  = ST_OK_LSB + MB_COUNT;

    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(MB_COUNT * (1 << FIELD_W));

    typedef logic [KEY_W-1:0]    prio_key_t;
    typedef logic [MB_IDX_W-1:0] mb_idx_t;

    typedef enum logic [FIELD_W-1:0] {
        FLD_IDENT = 2'd0,
        FLD_LEN   = 2'd1,
        FLD_DLO   = 2'd2,
        FLD_DHI   = 2'd3
    } mb_field_e;

    typedef struct packed {
        logic [WORD_W-1:0] ident;
        logic [LEN_W-1:0]  len;
        logic [WORD_W-1:0] dlo;
        logic [WORD_W-1:0] dhi;
    } mb_frame_t;

    typedef struct packed {
        logic empty;
        logic pending;
        logic abort;
        logic txok;
        logic active;
    } mb_flags_t;

    // Smaller key means higher bus priority.
    function automatic prio_key_t prio_key(input logic [WORD_W-1:0] w);
        logic ext;
        ext = w[IDE_BIT];
        return {w[WORD_W-1 -: STD_ID_W], ext,
                ext ? w[EXT_LSB +: EXT_LO_W] : {EXT_LO_W{1'b0}},
                w[RTR_BIT]};
    endfunction

endpackage

// File: rtl/txmb_slot.sv
module txmb_slot
    import can_txmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              auto_retry,
    input  logic              wr_me,
    input  mb_field_e         wr_field,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              abort_set,
    input  logic              start_me,
    input  logic              done_me,
    input  logic              lost_me,
    output mb_frame_t         frame,
    output mb_flags_t         flags
);

    mb_frame_t frame_q;
    mb_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q         <= '0;
            flags_q.empty   <= 1'b1;
            flags_q.pending <= 1'b0;
            flags_q.abort   <= 1'b0;
            flags_q.txok    <= 1'b0;
            flags_q.active  <= 1'b0;
        end else begin
            if (wr_me && flags_q.empty) begin
                case (wr_field)
                    FLD_IDENT: begin
                        frame_q.ident <= wr_data;
                        if (wr_data[REQ_BIT]) begin
                            flags_q.pending <= 1'b1;
                            flags_q.empty   <= 1'b0;
                            flags_q.txok    <= 1'b0;
                        end
                    end
                    FLD_LEN: frame_q.len <= wr_data[LEN_W-1:0];
                    FLD_DLO: frame_q.dlo <= wr_data;
                    default: frame_q.dhi <= wr_data;
                endcase
            end
            if (abort_set && !flags_q.empty) begin
                flags_q.abort <= 1'b1;
            end
            if (start_me) begin
                flags_q.active <= 1'b1;
            end
            if (flags_q.active) begin
                if (done_me) begin
                    flags_q.active  <= 1'b0;
                    flags_q.empty   <= 1'b1;
                    flags_q.pending <= 1'b0;
                    flags_q.abort   <= 1'b0;
                    flags_q.txok    <= 1'b1;
                end else if (lost_me) begin
                    flags_q.active <= 1'b0;
                    if (flags_q.abort || !auto_retry) begin
                        flags_q.empty   <= 1'b1;
                        flags_q.pending <= 1'b0;
                        flags_q.abort   <= 1'b0;
                        flags_q.txok    <= 1'b0;
                    end
                end
            end else if (flags_q.abort) begin
                flags_q.empty   <= 1'b1;
                flags_q.pending <= 1'b0;
                flags_q.abort   <= 1'b0;
                flags_q.txok    <= 1'b0;
            end
        end
    end

    assign frame = frame_q;
    assign flags = flags_q;

    a_r2_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_me && !flags_q.empty) |=> $stable(frame_q));
    a_r2_empty_not_pending: assert property (@(posedge clk) disable iff (rst)
        !(flags_q.empty && flags_q.pending));
    a_r8_done_sets_ok: assert property (@(posedge clk) disable iff (rst)
        done_me |=> (flags_q.empty && flags_q.txok && !flags_q.abort && !flags_q.active));
    a_r9_abort_resolves: assert property (@(posedge clk) disable iff (rst)
        (flags_q.abort && !flags_q.active) |=> (flags_q.empty && !flags_q.txok && !flags_q.abort));
    a_r10_retry_keeps: assert property (@(posedge clk) disable iff (rst)
        (lost_me && auto_retry && !flags_q.abort) |=> (flags_q.pending && !flags_q.active));
    a_r10_noretry_drops: assert property (@(posedge clk) disable iff (rst)
        (lost_me && (!auto_retry || flags_q.abort)) |=> (flags_q.empty && !flags_q.txok));

endmodule

// File: rtl/txmb_arbiter.sv
module txmb_arbiter
    import can_txmb_pkg::*;
(
    input  mb_frame_t frames [MB_COUNT],
    input  mb_flags_t flags  [MB_COUNT],
    output logic      best_valid,
    output mb_idx_t   best_idx,
    output mb_idx_t   code
);

    prio_key_t keys [MB_COUNT];
    prio_key_t best_key;
    prio_key_t low_key;
    mb_idx_t   low_idx;
    mb_idx_t   free_idx;
    logic      low_found;
    logic      free_found;

    for (genvar g = 0; g < MB_COUNT; g++) begin : g_key
        assign keys[g] = prio_key(frames[g].ident);
    end

    always_comb begin
        best_valid = 1'b0;
        best_idx   = '0;
        best_key   = '1;
        low_found  = 1'b0;
        low_idx    = '0;
        low_key    = '0;
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < MB_COUNT; i++) begin
            if (flags[i].pending && !flags[i].abort &&
                (!best_valid || keys[i] < best_key)) begin
                best_valid = 1'b1;
                best_idx   = MB_IDX_W'(i);
                best_key   = keys[i];
            end
            if (flags[i].empty && !free_found) begin
                free_found = 1'b1;
                free_idx   = MB_IDX_W'(i);
            end
            if (!flags[i].empty && (!low_found || keys[i] >= low_key)) begin
                low_found = 1'b1;
                low_idx   = MB_IDX_W'(i);
                low_key   = keys[i];
            end
        end
        code = free_found ? free_idx : low_idx;
    end

endmodule

// File: rtl/can_tx_mailbox_sched.sv
module can_tx_mailbox_sched
    import can_txmb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                auto_retry,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [WORD_W-1:0]   rd_data,
    output logic                offer_valid,
    output logic [MB_IDX_W-1:0] offer_idx,
    output logic [WORD_W-1:0]   offer_ident,
    output logic [LEN_W-1:0]    offer_len,
    output logic [WORD_W-1:0]   offer_dlo,
    output logic [WORD_W-1:0]   offer_dhi,
    input  logic                eng_start,
    input  logic                eng_done_ok,
    input  logic                eng_lost
);

    mb_frame_t frames [MB_COUNT];
    mb_flags_t flags  [MB_COUNT];
    logic      arb_valid;
    mb_idx_t   arb_idx;
    mb_idx_t   code;
    logic      busy;
    mb_idx_t   act_idx;
    logic      take;
    logic      wr_mb;
    logic      wr_status;
    logic [WORD_W-1:0] status_word;
    mb_frame_t sel_frame;

    assign take      = !busy && eng_start && arb_valid;
    assign wr_mb     = wr_en && (wr_addr < STATUS_ADDR);
    assign wr_status = wr_en && (wr_addr == STATUS_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            act_idx <= '0;
        end else if (busy) begin
            if (eng_done_ok || eng_lost) begin
                busy <= 1'b0;
            end
        end else if (take) begin
            busy    <= 1'b1;
            act_idx <= arb_idx;
        end
    end

    for (genvar g = 0; g < MB_COUNT; g++) begin : g_slot
        txmb_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .auto_retry (auto_retry),
            .wr_me      (wr_mb && (wr_addr[ADDR_W-1 -: MB_IDX_W] == MB_IDX_W'(g))),
            .wr_field   (mb_field_e'(wr_addr[FIELD_W-1:0])),
            .wr_data    (wr_data),
            .abort_set  (wr_status && wr_data[ST_ABORT_LSB + g]),
            .start_me   (take && (arb_idx == MB_IDX_W'(g))),
            .done_me    (busy && eng_done_ok && (act_idx == MB_IDX_W'(g))),
            .lost_me    (busy && eng_lost && !eng_done_ok && (act_idx == MB_IDX_W'(g))),
            .frame      (frames[g]),
            .flags      (flags[g])
        );
    end

    txmb_arbiter u_arb (
        .frames     (frames),
        .flags      (flags),
        .best_valid (arb_valid),
        .best_idx   (arb_idx),
        .code       (code)
    );

    assign offer_valid = arb_valid && !busy;
    assign offer_idx   = busy ? act_idx : arb_idx;
    assign sel_frame   = frames[offer_idx];
    assign offer_ident = sel_frame.ident;
    assign offer_len   = sel_frame.len;
    assign offer_dlo   = sel_frame.dlo;
    assign offer_dhi   = sel_frame.dhi;

    always_comb begin
        status_word = '0;
        for (int i = 0; i < MB_COUNT; i++) begin
            status_word[ST_EMPTY_LSB + i] = flags[i].empty;
            status_word[ST_PEND_LSB + i]  = flags[i].pending;
            status_word[ST_ABORT_LSB + i] = flags[i].abort;
            status_word[ST_OK_LSB + i]    = flags[i].txok;
        end
        status_word[ST_CODE_LSB +: MB_IDX_W] = code;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == STATUS_ADDR) begin
            rd_data = status_word;
        end else if (rd_addr < STATUS_ADDR) begin
            case (mb_field_e'(rd_addr[FIELD_W-1:0]))
                FLD_IDENT: rd_data = {frames[rd_addr[ADDR_W-1 -: MB_IDX_W]].ident[WORD_W-1:1],
                                      flags[rd_addr[ADDR_W-1 -: MB_IDX_W]].pending};
                FLD_LEN:   rd_data = WORD_W'(frames[rd_addr[ADDR_W-1 -: MB_IDX_W]].len);
                FLD_DLO:   rd_data = frames[rd_addr[ADDR_W-1 -: MB_IDX_W]].dlo;
                default:   rd_data = frames[rd_addr[ADDR_W-1 -: MB_IDX_W]].dhi;
            endcase
        end
    end

    logic [MB_COUNT-1:0] active_vec;
    always_comb begin
        for (int i = 0; i < MB_COUNT; i++) begin
            active_vec[i] = flags[i].active;
        end
    end

    a_r7_single_lock: assert property (@(posedge clk) disable iff (rst)
        $onehot0(active_vec));
    a_r7_lock_matches: assert property (@(posedge clk) disable iff (rst)
        busy |-> (flags[act_idx].active && !offer_valid));
    a_r5_code_free: assert property (@(posedge clk) disable iff (rst)
        (|{flags[0].empty, flags[1].empty, flags[2].empty}) |-> flags[code].empty);
    a_r9_no_offer_aborting: assert property (@(posedge clk) disable iff (rst)
        offer_valid |-> (flags[offer_idx].pending && !flags[offer_idx].abort));

    for (genvar j = 0; j < MB_COUNT; j++) begin : g_order
        a_r4_offer_beats_rest: assert property (@(posedge clk) disable iff (rst)
            (offer_valid && flags[j].pending && !flags[j].abort) |->
            ((prio_key(offer_ident) < prio_key(frames[j].ident)) ||
             (prio_key(offer_ident) == prio_key(frames[j].ident) && offer_idx <= MB_IDX_W'(j))));
    end

endmodule

// File: tb/sim_can_tx_mailbox_sched.sv
module sim_can_tx_mailbox_sched;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] ST_ADDR = 4'd12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        auto_retry = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        offer_valid;
    logic [1:0]  offer_idx;
    logic [31:0] offer_ident, offer_dlo, offer_dhi;
    logic [3:0]  offer_len;
    logic        eng_start = 1'b0, eng_done_ok = 1'b0, eng_lost = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] m_id [3];
    logic [31:0] m_lo [3];
    logic [31:0] m_hi [3];
    logic [3:0]  m_len [3];
    logic [2:0]  m_empty, m_pend, m_abt, m_ok;
    logic        m_busy;
    int          m_act;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_tx_mailbox_sched u0 (
        .clk(clk), .rst(rst), .auto_retry(auto_retry),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .offer_valid(offer_valid), .offer_idx(offer_idx), .offer_ident(offer_ident),
        .offer_len(offer_len), .offer_dlo(offer_dlo), .offer_dhi(offer_dhi),
        .eng_start(eng_start), .eng_done_ok(eng_done_ok), .eng_lost(eng_lost)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Rule-by-rule priority: true when a beats b.
    function automatic bit beats(input logic [31:0] a, input logic [31:0] b);
        if (a[31:21] != b[31:21]) return a[31:21] < b[31:21];
        if (a[2] != b[2]) return !a[2];
        if (a[2] && a[20:3] != b[20:3]) return a[20:3] < b[20:3];
        return !a[1] && b[1];
    endfunction

    function automatic int f_best();
        int b = -1;
        for (int i = 0; i < 3; i++)
            if (m_pend[i] && !m_abt[i] && (b < 0 || beats(m_id[i], m_id[b]))) b = i;
        return b;
    endfunction

    function automatic int f_code();
        int l = -1;
        for (int i = 0; i < 3; i++) if (m_empty[i]) return i;
        for (int i = 0; i < 3; i++)
            if (l < 0 || !beats(m_id[i], m_id[l])) l = i;
        return l;
    endfunction

    function automatic logic [31:0] f_status();
        logic [31:0] s = '0;
        s[2:0] = m_empty; s[5:3] = m_pend; s[8:6] = m_abt; s[11:9] = m_ok;
        s[13:12] = 2'(f_code());
        return s;
    endfunction

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        int b;
        rd(ST_ADDR, v);
        chk({tag, " status"}, v, f_status());
        b = f_best();
        if (!m_busy) begin
            chk({tag, " offer_valid"}, 32'(offer_valid), 32'(b >= 0));
            if (b >= 0) begin
                chk({tag, " offer_idx R4"}, 32'(offer_idx), 32'(b));
                chk({tag, " R6 ident"}, offer_ident, m_id[b]);
                chk({tag, " R6 len"}, 32'(offer_len), 32'(m_len[b]));
                chk({tag, " R6 dlo"}, offer_dlo, m_lo[b]);
                chk({tag, " R6 dhi"}, offer_dhi, m_hi[b]);
            end
        end else begin
            chk({tag, " R7 locked no offer"}, 32'(offer_valid), 32'd0);
        end
    endtask

    task automatic do_load(input int i, input logic [31:0] id, input logic [3:0] ln,
                           input logic [31:0] lo, input logic [31:0] hi);
        wr(4'(i*4+1), {28'h1234567, ln});
        wr(4'(i*4+2), lo);
        wr(4'(i*4+3), hi);
        wr(4'(i*4+0), id);
        if (m_empty[i]) begin
            m_len[i] = ln; m_lo[i] = lo; m_hi[i] = hi; m_id[i] = id;
            if (id[0]) begin m_pend[i] = 1; m_empty[i] = 0; m_ok[i] = 0; end
        end
    endtask

    task automatic do_start();
        eng_start = 1'b1;
        @(negedge clk);
        eng_start = 1'b0;
        m_busy = 1; m_act = f_best();
    endtask

    task automatic do_finish(input bit ok);
        if (ok) eng_done_ok = 1'b1; else eng_lost = 1'b1;
        @(negedge clk);
        eng_done_ok = 1'b0; eng_lost = 1'b0;
        m_busy = 0;
        if (ok) begin
            m_empty[m_act] = 1; m_pend[m_act] = 0; m_abt[m_act] = 0; m_ok[m_act] = 1;
        end else if (!auto_retry || m_abt[m_act]) begin
            m_empty[m_act] = 1; m_pend[m_act] = 0; m_abt[m_act] = 0; m_ok[m_act] = 0;
        end
    endtask

    task automatic do_abort(input int i);
        wr(ST_ADDR, 32'h1 << (6 + i));
        if (!m_empty[i]) m_abt[i] = 1;
        check_all("R9 abort visible");
        @(negedge clk);
        if (m_abt[i] && !(m_busy && m_act == i)) begin
            m_empty[i] = 1; m_pend[i] = 0; m_abt[i] = 0; m_ok[i] = 0;
        end
        check_all("R9 abort resolved");
    endtask

    function automatic logic [31:0] rnd_id();
        logic [10:0] base = 11'h120 + 11'($urandom_range(0, 3));
        logic [17:0] lo18 = 18'($urandom_range(0, 2));
        logic ide = 1'($urandom_range(0, 1));
        logic rtr = 1'($urandom_range(0, 1));
        return {base, lo18, ide, rtr, 1'b1};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        m_empty = 3'b111; m_pend = '0; m_abt = '0; m_ok = '0; m_busy = 0; m_act = 0;
        for (int i = 0; i < 3; i++) begin m_id[i] = '0; m_lo[i] = '0; m_hi[i] = '0; m_len[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(ST_ADDR, v);
        chk("R1 status", v, 32'h0000_0007);
        chk("R1 offer_valid", 32'(offer_valid), 32'd0);

        // R3: ext base 0x100, std 0x100 remote, std 0x100 data
        do_load(0, {11'h100, 18'd5, 1'b1, 1'b0, 1'b1}, 4'd8, 32'hA0A0_0001, 32'hB0B0_0001);
        check_all("R5 code next free");
        do_load(1, {11'h100, 18'h3FFFF, 1'b0, 1'b1, 1'b1}, 4'd2, 32'hA0A0_0002, 32'hB0B0_0002);
        do_load(2, {11'h100, 18'h00000, 1'b0, 1'b0, 1'b1}, 4'd15, 32'hA0A0_0003, 32'hB0B0_0003);
        check_all("R3 std data beats std remote beats ext");
        chk("R3 offer idx", 32'(offer_idx), 32'd2);
        rd(ST_ADDR, v);
        chk("R5 full code lowest prio", 32'(v[13:12]), 32'd0);

        // R2 write to a full mailbox is ignored
        wr(4'd0, 32'h0000_0001);
        wr(4'd1, 32'h0000_0003);
        rd(4'd0, v); chk("R2 ident kept", v, {11'h100, 18'd5, 1'b1, 1'b0, 1'b1});
        rd(4'd1, v); chk("R2 len kept", v, 32'd8);

        // R9 abort waiting best mailbox, then abort an empty one
        do_abort(2);
        chk("R9 offer moves to 1", 32'(offer_idx), 32'd1);
        do_abort(2);

        // R7 lock, abort during lock waits, R8 done
        do_start();
        check_all("R7 locked");
        do_abort(1);
        rd(ST_ADDR, v); chk("R7 abort held while locked", 32'(v[7]), 32'd1);
        do_finish(1'b1);
        check_all("R8 done sets ok");

        // R4 tie on identical words
        do_load(1, {11'h100, 18'd5, 1'b1, 1'b0, 1'b1}, 4'd1, 32'h11, 32'h22);
        check_all("R4 tie lower index");
        chk("R4 tie idx", 32'(offer_idx), 32'd0);
        do_load(2, {11'h100, 18'd5, 1'b1, 1'b0, 1'b1}, 4'd3, 32'h33, 32'h44);
        rd(ST_ADDR, v); chk("R5 tie code highest index", 32'(v[13:12]), 32'd2);

        // R10 lost with retry, then without
        auto_retry = 1'b1;
        do_start();
        do_finish(1'b0);
        check_all("R10 retry keeps pending");
        chk("R10 re-offered idx", 32'(offer_idx), 32'd0);
        auto_retry = 1'b0;
        do_start();
        do_finish(1'b0);
        check_all("R10 no retry drops");

        // clear remaining mailboxes
        for (int i = 0; i < 3; i++) if (!m_empty[i]) do_abort(i);

        // random phase
        for (int it = 0; it < 250; it++) begin
            for (int i = 0; i < 3; i++)
                if (m_empty[i] && $urandom_range(0, 1) == 1)
                    do_load(i, rnd_id(), 4'($urandom), $urandom, $urandom);
            check_all("R3 random arbitration");
            if ($urandom_range(0, 7) == 0) do_abort($urandom_range(0, 2));
            if (f_best() >= 0) begin
                do_start();
                check_all("R7 random lock");
                if ($urandom_range(0, 3) == 0) do_abort(m_act);
                auto_retry = 1'($urandom_range(0, 1));
                do_finish(1'($urandom_range(0, 1)));
                check_all("R8 R10 random finish");
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule